// File: doc/BRIEF.md
# Serial Port Control Register with Address-Wait Filter

This block holds the eight-bit control word of a serial communication unit and turns it into the control signals around it. The CPU writes and reads the word through a simple register port. Each bit then acts on one part of the unit:

- four bits gate the interrupt requests raised from transmitter and receiver status levels;
- two bits enable the transmitter and the receiver, and also give the receive pin its role;
- two bits pick the clock source and the role of the serial clock pin. The meaning of these two bits depends on a separate asynchronous/synchronous mode input.

One bit is an address-wait bit, used when several stations share a line. While it is set, all receive status flags are held off and both receive interrupts are held off. This lasts until a frame whose address marker is 1 arrives. That frame is received normally, and the hardware clears the bit at the same edge. The shift engines, the baud generator and the status register storage are outside this block. The block sees them only through level and pulse inputs.

Top module: `sercfg_ctl`

## Requirements
- R1: After reset, all eight control bits read as 0. In that state `cfg_illegal` is 0, every interrupt output is 0 whatever the status levels are, `rx_flag_set_en` is 1, and `clk_pin_mode` is 0 (port).
- R2: A cycle with `wr_en` high stores `wr_data` at the clock edge. From the next cycle `rd_data` returns it. The bit layout from bit 7 down to bit 0 is: transmit-empty irq enable, receive irq enable, transmitter enable, receiver enable, address-wait, transmit-done irq enable, clock code bit 1, clock code bit 0.
- R3: `irq_tx_empty` equals bit 7 AND `st_tx_empty`. `irq_tx_done` equals bit 2 AND `st_tx_end`.
- R4: `irq_rx_full` equals bit 6 AND NOT bit 3 AND `st_rx_full`. `irq_rx_err` equals bit 6 AND NOT bit 3 AND (`st_frame_err` OR `st_overrun`).
- R5: `rx_flag_set_en` is 0 while bit 3 is 1. The exception is the cycle in which `rx_frame_done` and `rx_addr_bit` are both 1, where it is 1.
- R6: A frame pulse with `rx_addr_bit` = 1 clears bit 3 at that edge. A frame pulse with `rx_addr_bit` = 0 leaves bit 3 unchanged.
- R7: If a write and an address frame fall in the same cycle, bit 3 becomes 0 and the other seven bits take the written value.
- R8: `tx_enable` follows bit 5. `rx_pin_serial` follows bit 4: 1 means the pin is the serial input, 0 means it is a general port.
- R9: With `sync_mode` = 0, the clock codes decode as follows. `clk_pin_mode` encodes 0 = port, 1 = clock out, 2 = clock in.

  | Clock code | Clock source | `clk_pin_mode` |
  |---|---|---|
  | 00 | internal | 0 (port) |
  | 01 | internal | 1 (clock out) |
  | 10 | external | 2 (clock in) |

- R10: With `sync_mode` = 1, clock code 00 gives an internal clock with `clk_pin_mode` = 1 (clock out). Clock code 10 gives an external clock with `clk_pin_mode` = 2 (clock in).
- R11: Some clock codes are reserved: 11 in both modes, and 01 when `sync_mode` = 1. Writing a reserved code stores it as written. It sets `cfg_illegal` at that same edge, and the flag stays 1 until reset. While a reserved code is stored, the pin is a port (0) and the clock source is internal.
- R12: The interrupt outputs are combinational from stored state. An interrupt output falls in the first cycle after the write that clears its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous framing |
| wr_en | input | 1 | CPU write strobe for the control word |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current control word |
| rx_frame_done | input | 1 | One-cycle pulse: a frame was received |
| rx_addr_bit | input | 1 | Address marker of that frame |
| st_rx_full | input | 1 | Receive data full status level |
| st_frame_err | input | 1 | Framing error status level |
| st_overrun | input | 1 | Overrun status level |
| st_tx_empty | input | 1 | Transmit data empty status level |
| st_tx_end | input | 1 | Transmission complete status level |
| irq_tx_empty | output | 1 | Gated transmit-empty request |
| irq_rx_full | output | 1 | Gated receive-full request |
| irq_rx_err | output | 1 | Gated receive-error request |
| irq_tx_done | output | 1 | Gated transmit-done request |
| rx_flag_set_en | output | 1 | Permits setting receive full, framing and overrun flags |
| tx_enable | output | 1 | Transmitter enable |
| rx_pin_serial | output | 1 | Receive pin used as serial input |
| clk_pin_mode | output | 2 | Clock pin role: 0 port, 1 clock out, 2 clock in |
| clk_src_ext | output | 1 | 1 selects the external clock |
| cfg_illegal | output | 1 | Sticky flag for a reserved clock code |

## Verification
The gating is exercised with control words that each switch on one enable or a pair of enables, set against status patterns that raise all levels or only one. This separates cross-wiring between the four requests and shows that a framing error and an overrun each raise the error request alone. Every legal clock code is applied in both modes, which shows whether the decode uses the mode input. The address-wait sequence sends a data frame first and then an address frame. This tells "cleared by any frame" apart from "cleared only by an address frame" and checks that the address frame itself is let through. A write that lands in the same cycle as the clear shows that only bit 3 yields to the hardware.

// File: rtl/sercfg_pkg.sv
// Package: shared widths, bit positions of the control word, clock pin roles.
// Assumes an eight-bit control word whose layout software relies on.
package sercfg_pkg;
    localparam int CTL_W   = 8;
    localparam int CLKC_W  = 2;
    localparam int B_TXEIE = 7;
    localparam int B_RXIE  = 6;
    localparam int B_TXEN  = 5;
    localparam int B_RXEN  = 4;
    localparam int B_WAIT  = 3;
    localparam int B_TDIE  = 2;

    typedef enum logic [1:0] {
        PIN_PORT    = 2'd0,
        PIN_CLK_OUT = 2'd1,
        PIN_CLK_IN  = 2'd2
    } pin_role_e;
endpackage

// File: rtl/sercfg_store.sv
// Control word storage. CPU writes load the word. An address frame clears the
// wait bit, and that clear takes priority over a write to the same bit.
// Assumes rx_frame_done is a one-cycle pulse.
module sercfg_store
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             rx_frame_done,
    input  logic             rx_addr_bit,
    output logic [CTL_W-1:0] ctl_q,
    output logic             wait_clr
);
    // Purpose: detect the hardware clear event.
    always_comb wait_clr = rx_frame_done & rx_addr_bit;

    // Purpose: hold the control word; a hardware clear overrides bit B_WAIT only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (wr_en)
                ctl_q <= wr_data;
            if (wait_clr)
                ctl_q[B_WAIT] <= 1'b0;
        end
    end

    assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wait_clr) |=> ctl_q == $past(wr_data));
    assert_wait_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_clr |=> !ctl_q[B_WAIT]);
    assert_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wait_clr) |=> ctl_q[CTL_W-1:B_WAIT+1] == $past(wr_data[CTL_W-1:B_WAIT+1]));
    assert_data_frame_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done && !rx_addr_bit && !wr_en) |=> $stable(ctl_q));
endmodule

// File: rtl/sercfg_clksel.sv
// Clock code decode. Maps the two clock bits and the mode input to a clock
// source and a pin role. Flags reserved codes on write with a sticky bit.
// Assumes a reserved code must act as internal clock, pin as port.
module sercfg_clksel
    import sercfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic [CLKC_W-1:0] code_q,
    input  logic              wr_en,
    input  logic [CLKC_W-1:0] wr_code,
    output pin_role_e         pin_role,
    output logic              src_ext,
    output logic              illegal_q
);
    // Reserved in both modes: 11; reserved in synchronous mode only: 01.
    function automatic logic is_reserved(input logic [CLKC_W-1:0] c, input logic sm);
        return (c == 2'b11) || (sm && c == 2'b01);
    endfunction

    // Purpose: decode the stored code in the current mode.
    always_comb begin
        pin_role = PIN_PORT;
        src_ext  = 1'b0;
        if (!is_reserved(code_q, sync_mode)) begin
            case (code_q)
                2'b00:   pin_role = sync_mode ? PIN_CLK_OUT : PIN_PORT;
                2'b01:   pin_role = PIN_CLK_OUT;
                2'b10: begin
                    pin_role = PIN_CLK_IN;
                    src_ext  = 1'b1;
                end
                default: pin_role = PIN_PORT;
            endcase
        end
    end

    // Purpose: sticky record of a reserved code written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal_q <= 1'b0;
        else if (wr_en && is_reserved(wr_code, sync_mode))
            illegal_q <= 1'b1;
    end

    assert_illegal_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |=> illegal_q);
    assert_pin_role_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_role != 2'd3);
    assert_ext_is_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        src_ext |-> pin_role == PIN_CLK_IN);
endmodule

// File: rtl/sercfg_irq.sv
// Interrupt gating. Each request is its enable bit ANDed with a status level.
// Receive requests are also held off while the address-wait bit is set.
// Assumes status inputs are levels kept by the external status register.
module sercfg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic txe_ie,
    input  logic rx_ie,
    input  logic td_ie,
    input  logic wait_q,
    input  logic st_rx_full,
    input  logic st_frame_err,
    input  logic st_overrun,
    input  logic st_tx_empty,
    input  logic st_tx_end,
    output logic irq_tx_empty,
    output logic irq_rx_full,
    output logic irq_rx_err,
    output logic irq_tx_done
);
    logic rx_open;

    // Purpose: combine the enables with the status levels.
    always_comb begin
        rx_open      = rx_ie & ~wait_q;
        irq_tx_empty = txe_ie & st_tx_empty;
        irq_tx_done  = td_ie & st_tx_end;
        irq_rx_full  = rx_open & st_rx_full;
        irq_rx_err   = rx_open & (st_frame_err | st_overrun);
    end

    assert_rx_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> !(irq_rx_full || irq_rx_err));
    assert_tx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |-> st_tx_empty);
    assert_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ie) |-> !irq_rx_full && !irq_rx_err);
endmodule

// File: rtl/sercfg_ctl.sv
// Top: serial port control register with address-wait filter. Connects the
// word storage, the clock decode and the interrupt gating, and exports the
// enables and the receive flag permit.
// Assumes synchronous active-low reset and one clock domain.
module sercfg_ctl
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    input  logic             rx_frame_done,
    input  logic             rx_addr_bit,
    input  logic             st_rx_full,
    input  logic             st_frame_err,
    input  logic             st_overrun,
    input  logic             st_tx_empty,
    input  logic             st_tx_end,
    output logic             irq_tx_empty,
    output logic             irq_rx_full,
    output logic             irq_rx_err,
    output logic             irq_tx_done,
    output logic             rx_flag_set_en,
    output logic             tx_enable,
    output logic             rx_pin_serial,
    output logic [1:0]       clk_pin_mode,
    output logic             clk_src_ext,
    output logic             cfg_illegal
);
    logic [CTL_W-1:0] ctl_q;
    logic             wait_clr;
    pin_role_e        pin_role;

    sercfg_store u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rx_frame_done (rx_frame_done),
        .rx_addr_bit   (rx_addr_bit),
        .ctl_q         (ctl_q),
        .wait_clr      (wait_clr)
    );

    sercfg_clksel u_clksel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .code_q    (ctl_q[CLKC_W-1:0]),
        .wr_en     (wr_en),
        .wr_code   (wr_data[CLKC_W-1:0]),
        .pin_role  (pin_role),
        .src_ext   (clk_src_ext),
        .illegal_q (cfg_illegal)
    );

    sercfg_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .txe_ie       (ctl_q[B_TXEIE]),
        .rx_ie        (ctl_q[B_RXIE]),
        .td_ie        (ctl_q[B_TDIE]),
        .wait_q       (ctl_q[B_WAIT]),
        .st_rx_full   (st_rx_full),
        .st_frame_err (st_frame_err),
        .st_overrun   (st_overrun),
        .st_tx_empty  (st_tx_empty),
        .st_tx_end    (st_tx_end),
        .irq_tx_empty (irq_tx_empty),
        .irq_rx_full  (irq_rx_full),
        .irq_rx_err   (irq_rx_err),
        .irq_tx_done  (irq_tx_done)
    );

    // Purpose: export stored state and the receive flag permit.
    always_comb begin
        rd_data        = ctl_q;
        tx_enable      = ctl_q[B_TXEN];
        rx_pin_serial  = ctl_q[B_RXEN];
        clk_pin_mode   = pin_role;
        rx_flag_set_en = ~ctl_q[B_WAIT] | wait_clr;
    end

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_WAIT] && !(rx_frame_done && rx_addr_bit)) |-> !rx_flag_set_en);
endmodule

// File: tb/sercfg_ctl_bench.sv
module sercfg_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_frame_done = 1'b0;
    logic       rx_addr_bit = 1'b0;
    logic       st_rx_full = 1'b0, st_frame_err = 1'b0, st_overrun = 1'b0;
    logic       st_tx_empty = 1'b0, st_tx_end = 1'b0;
    logic       irq_tx_empty, irq_rx_full, irq_rx_err, irq_tx_done;
    logic       rx_flag_set_en, tx_enable, rx_pin_serial, clk_src_ext, cfg_illegal;
    logic [1:0] clk_pin_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sercfg_ctl u_sercfg_ctl (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rx_frame_done(rx_frame_done),
        .rx_addr_bit(rx_addr_bit), .st_rx_full(st_rx_full),
        .st_frame_err(st_frame_err), .st_overrun(st_overrun),
        .st_tx_empty(st_tx_empty), .st_tx_end(st_tx_end),
        .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full),
        .irq_rx_err(irq_rx_err), .irq_tx_done(irq_tx_done),
        .rx_flag_set_en(rx_flag_set_en), .tx_enable(tx_enable),
        .rx_pin_serial(rx_pin_serial), .clk_pin_mode(clk_pin_mode),
        .clk_src_ext(clk_src_ext), .cfg_illegal(cfg_illegal)
    );

    // Vector: {sync, word, status{rx_full,frame_err,overrun,tx_empty,tx_end},
    //          irq{tx_empty,rx_full,rx_err,tx_done}, pin role, ext}
    localparam logic [20:0] VEC [8] = '{
        {1'b0, 8'hC4, 5'b11111, 4'b1111, 2'd0, 1'b0},
        {1'b0, 8'hCC, 5'b11111, 4'b1001, 2'd0, 1'b0},
        {1'b0, 8'h41, 5'b01000, 4'b0010, 2'd1, 1'b0},
        {1'b0, 8'h42, 5'b00100, 4'b0010, 2'd2, 1'b1},
        {1'b1, 8'h80, 5'b00010, 4'b1000, 2'd1, 1'b0},
        {1'b1, 8'h06, 5'b00001, 4'b0001, 2'd2, 1'b1},
        {1'b0, 8'h30, 5'b11111, 4'b0000, 2'd0, 1'b0},
        {1'b0, 8'h40, 5'b10000, 4'b0100, 2'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_status(input logic [4:0] s);
        {st_rx_full, st_frame_err, st_overrun, st_tx_empty, st_tx_end} = s;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rx_frame_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write at the next edge; return at the following negedge.
    task automatic cpu_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [3:0] irqs();
        return {irq_tx_empty, irq_rx_full, irq_rx_err, irq_tx_done};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        set_status(5'b11111);
        #1;
        chk("R1 word", rd_data, 8'h00);
        chk("R1 irqs", irqs(), 4'b0000);
        chk("R1 illegal", cfg_illegal, 1'b0);
        chk("R1 flag_en", rx_flag_set_en, 1'b1);
        chk("R1 pin", clk_pin_mode, 2'd0);

        // Table walk: R2, R3, R4, R8, R9, R10, R5
        foreach (VEC[i]) begin
            sync_mode = VEC[i][20];
            set_status(VEC[i][11:7]);
            cpu_write(VEC[i][19:12]);
            chk("R2 readback", rd_data, VEC[i][19:12]);
            chk("R3/R4 irqs", irqs(), VEC[i][6:3]);
            chk("R8 tx_enable", tx_enable, VEC[i][17]);
            chk("R8 rx_pin", rx_pin_serial, VEC[i][16]);
            chk(VEC[i][20] ? "R10 pin" : "R9 pin", clk_pin_mode, VEC[i][2:1]);
            chk(VEC[i][20] ? "R10 ext" : "R9 ext", clk_src_ext, VEC[i][0]);
            chk("R5 flag_en", rx_flag_set_en, !VEC[i][15]);
        end

        // R12: enable cleared -> request low in the next cycle
        sync_mode = 1'b0;
        set_status(5'b11111);
        cpu_write(8'hC4);
        chk("R12 before", irqs(), 4'b1111);
        cpu_write(8'h00);
        chk("R12 after", irqs(), 4'b0000);

        // R5/R6: address-wait filter
        do_reset();
        set_status(5'b10000);
        cpu_write(8'h48);
        chk("R5 blocked", rx_flag_set_en, 1'b0);
        chk("R4 blocked", irq_rx_full, 1'b0);
        rx_frame_done = 1'b1; rx_addr_bit = 1'b0;
        #1;
        chk("R5 data frame", rx_flag_set_en, 1'b0);
        @(negedge clk);
        rx_frame_done = 1'b0;
        chk("R6 data frame keeps", rd_data, 8'h48);
        rx_frame_done = 1'b1; rx_addr_bit = 1'b1;
        #1;
        chk("R5 addr frame passes", rx_flag_set_en, 1'b1);
        @(negedge clk);
        rx_frame_done = 1'b0; rx_addr_bit = 1'b0;
        chk("R6 cleared", rd_data, 8'h40);
        chk("R6 irq open", irq_rx_full, 1'b1);

        // R7: write and address frame collide
        cpu_write(8'h48);
        rx_frame_done = 1'b1; rx_addr_bit = 1'b1;
        cpu_write(8'hCD);
        rx_frame_done = 1'b0; rx_addr_bit = 1'b0;
        chk("R7 collision", rd_data, 8'hC5);

        // R11: reserved codes
        do_reset();
        sync_mode = 1'b0;
        cpu_write(8'h01);
        chk("R11 async 01 legal", cfg_illegal, 1'b0);
        cpu_write(8'h03);
        chk("R11 stored", rd_data, 8'h03);
        chk("R11 flag", cfg_illegal, 1'b1);
        chk("R11 pin port", clk_pin_mode, 2'd0);
        chk("R11 internal", clk_src_ext, 1'b0);
        cpu_write(8'h00);
        chk("R11 sticky", cfg_illegal, 1'b1);
        do_reset();
        sync_mode = 1'b1;
        cpu_write(8'h01);
        chk("R11 sync 01 flag", cfg_illegal, 1'b1);
        chk("R11 sync 01 pin", clk_pin_mode, 2'd0);
        do_reset();
        #1;
        chk("R1 flag cleared", cfg_illegal, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule